// File: doc/BRIEF.md
# Multi-Wavefront Instruction Issue Arbiter

This block decides, every clock cycle, which head instructions leave the per-wavefront instruction buffers of a compute unit. The unit has four SIMD groups. Each group owns ten wavefront buffer slots. Every slot presents a valid flag, a 3-bit type code for its head instruction and a flag that marks a special instruction as a barrier. Each of the six execution pipelines presents a ready flag.

Each cycle the arbiter turns to the next SIMD in round-robin order. From that SIMD's ten slots it picks the oldest eligible wavefront for each instruction type. It then keeps at most five of those picks, with the lowest type codes first. Special instructions retire inside the buffer and need no pipeline. A barrier special also takes one of sixteen barrier tracking entries, and an entry is handed back through a release pulse. The grant vector, the per-slot type codes, the selected SIMD and the barrier occupancy are all registered.

The buffers use the grant vector to pop their heads. The execution pipelines use the type fields to steer the issued instructions.

Top module: `wave_issue_arbiter`

## Requirements
- R1: While reset is asserted and right after it is released, `iss_grant` and `iss_type` are zero, `bar_used` is zero and `iss_simd` is 3, which is the last SIMD.
- R2: SIMDs are taken in the order 0,1,2,3,0,... with one SIMD per clock edge. Each edge moves to the next SIMD even when that SIMD has nothing to grant. `iss_simd` shows the SIMD whose result is on the other outputs.
- R3: Bit w of `iss_grant` refers to slot w of the selected SIMD s, which is flat slot index s*10+w of the inputs. A bit is set only if that slot's `head_valid` was high when the inputs were sampled.
- R4: Type codes are 0 branch, 1 scalar ALU/memory, 2 vector ALU, 3 vector memory, 4 local data share, 5 global data share/export and 6 special. Code 7 is never granted. At most one slot of each type is granted per cycle, so every grant comes from a different wavefront.
- R5: A slot with type code t from 0 to 5 is granted only while `pipe_ready[t]` is high.
- R6: A special slot (code 6) does not depend on `pipe_ready`. It is granted even when every ready bit is low.
- R7: Within one type, the slot with the largest age wins, and ties go to the lowest slot index. Each flat slot has an age that is cleared on a cycle where the slot is invalid or granted. Otherwise the age adds one, up to a limit of 15.
- R8: When more than five types have an eligible slot, only the five lowest type codes are granted.
- R9: A special slot with `head_barrier` set is eligible only while `bar_used` is below 16. Granting it adds one to `bar_used`. `bar_release` takes one away when `bar_used` is nonzero, and both changes can happen on the same edge.
- R10: Field `iss_type[3w+2:3w]` holds the type code of the slot granted on bit w, and is zero where bit w is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| head_valid | input | 40 | Head instruction present, flat slot s*10+w |
| head_type | input | 120 | 3-bit head type code per flat slot |
| head_barrier | input | 40 | Special head is a barrier, per flat slot |
| pipe_ready | input | 6 | Ready flag of the pipeline for type codes 0..5 |
| bar_release | input | 1 | Frees one barrier tracking entry |
| iss_simd | output | 2 | SIMD that the current grants belong to |
| iss_grant | output | 10 | Grant per slot of that SIMD |
| iss_type | output | 30 | Type code per granted slot |
| bar_used | output | 5 | Barrier tracking entries in use |

## Verification
All outputs are registered. A decision made from the inputs present before a rising edge therefore appears on the ports just after that edge, and the barrier count changes on that same edge. The bench drives inputs at the falling edge. It predicts the result from its own model of rotation, ages and barrier occupancy. It reads the outputs at the next falling edge, exactly one rising edge later. Age-sensitive cases hold the inputs for many cycles so that the predicted ages build up, and some of them reach the limit of 15.

// File: rtl/wave_issue_pkg.sv
package wave_issue_pkg;
  localparam int unsigned TYPE_W     = 3;
  localparam int unsigned NUM_ITYPES = 7;

  typedef enum logic [TYPE_W-1:0] {
    IT_BRANCH  = 3'd0,
    IT_SCALAR  = 3'd1,
    IT_VALU    = 3'd2,
    IT_VMEM    = 3'd3,
    IT_LDS     = 3'd4,
    IT_GDS     = 3'd5,
    IT_SPECIAL = 3'd6,
    IT_NONE    = 3'd7
  } itype_e;
endpackage

// File: rtl/wia_age_track.sv
module wia_age_track #(
  parameter int unsigned SLOTS = 40,
  parameter int unsigned AGE_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SLOTS-1:0]       valid_i,
  input  logic [SLOTS-1:0]       clear_i,
  output logic [SLOTS*AGE_W-1:0] age_o
);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [AGE_W-1:0] age_q, age_d;
    logic             age_en;

    always_comb begin
      age_en = 1'b1;
      if (!valid_i[s] || clear_i[s]) begin
        age_d = '0;
      end else if (age_q != AGE_MAX) begin
        age_d = age_q + 1'b1;
      end else begin
        age_d  = age_q;
        age_en = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      age_q <= '0;
      else if (age_en) age_q <= age_d;
    end

    assign age_o[s*AGE_W +: AGE_W] = age_q;
  end
endmodule

// File: rtl/wia_oldest_pick.sv
module wia_oldest_pick #(
  parameter int unsigned WAVES = 10,
  parameter int unsigned AGE_W = 4
) (
  input  logic [WAVES-1:0]       elig_i,
  input  logic [WAVES*AGE_W-1:0] age_i,
  output logic [WAVES-1:0]       pick_o,
  output logic                   found_o
);
  logic [AGE_W-1:0] best_age;
  int               best;

  always_comb begin
    found_o  = 1'b0;
    best_age = '0;
    best     = 0;
    pick_o   = '0;
    for (int w = 0; w < int'(WAVES); w++) begin
      if (elig_i[w] && (!found_o || age_i[w*AGE_W +: AGE_W] > best_age)) begin
        found_o  = 1'b1;
        best_age = age_i[w*AGE_W +: AGE_W];
        best     = w;
      end
    end
    if (found_o) pick_o[best] = 1'b1;
  end
endmodule

// File: rtl/wia_issue_cap.sv
module wia_issue_cap #(
  parameter int unsigned NUM_T     = 7,
  parameter int unsigned MAX_ISSUE = 5
) (
  input  logic [NUM_T-1:0] found_i,
  output logic [NUM_T-1:0] keep_o
);
  int taken;

  always_comb begin
    taken  = 0;
    keep_o = '0;
    for (int t = 0; t < int'(NUM_T); t++) begin
      if (found_i[t] && taken < int'(MAX_ISSUE)) begin
        keep_o[t] = 1'b1;
        taken     = taken + 1;
      end
    end
  end
endmodule

// File: rtl/wia_bar_track.sv
module wia_bar_track #(
  parameter int unsigned BAR_ENTRIES = 16,
  localparam int unsigned BAR_W      = $clog2(BAR_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic             release_i,
  output logic             room_o,
  output logic [BAR_W-1:0] used_o
);
  logic [BAR_W-1:0] used_q, used_d;
  logic             rel_eff, used_en;

  always_comb begin
    rel_eff = release_i && (used_q != '0);
    used_en = take_i ^ rel_eff;
    used_d  = take_i ? used_q + 1'b1 : used_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       used_q <= '0;
    else if (used_en) used_q <= used_d;
  end

  assign room_o = used_q < BAR_W'(BAR_ENTRIES);
  assign used_o = used_q;
endmodule

// File: rtl/wave_issue_arbiter.sv
module wave_issue_arbiter
  import wave_issue_pkg::*;
#(
  parameter int unsigned NUM_SIMD    = 4,
  parameter int unsigned WAVES       = 10,
  parameter int unsigned MAX_ISSUE   = 5,
  parameter int unsigned BAR_ENTRIES = 16,
  parameter int unsigned AGE_W       = 4,
  localparam int unsigned SLOTS      = NUM_SIMD * WAVES,
  localparam int unsigned SIMD_W     = $clog2(NUM_SIMD),
  localparam int unsigned BAR_W      = $clog2(BAR_ENTRIES + 1),
  localparam int unsigned NUM_PIPES  = NUM_ITYPES - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SLOTS-1:0]        head_valid,
  input  logic [SLOTS*TYPE_W-1:0] head_type,
  input  logic [SLOTS-1:0]        head_barrier,
  input  logic [NUM_PIPES-1:0]    pipe_ready,
  input  logic                    bar_release,
  output logic [SIMD_W-1:0]       iss_simd,
  output logic [WAVES-1:0]        iss_grant,
  output logic [WAVES*TYPE_W-1:0] iss_type,
  output logic [BAR_W-1:0]        bar_used
);
  localparam int SPEC = int'(IT_SPECIAL);

  // SIMD rotation
  logic [SIMD_W-1:0] rr_q, rr_d;

  always_comb begin
    rr_d = (rr_q == SIMD_W'(NUM_SIMD - 1)) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

  // Slot view of the selected SIMD
  logic [SLOTS*AGE_W-1:0] age_all;
  logic [WAVES-1:0]       sel_valid, sel_bar;
  logic [TYPE_W-1:0]      sel_type [WAVES];
  logic [WAVES*AGE_W-1:0] sel_age;

  always_comb begin
    for (int w = 0; w < int'(WAVES); w++) begin
      sel_valid[w]                = head_valid[int'(rr_q)*WAVES + w];
      sel_bar[w]                  = head_barrier[int'(rr_q)*WAVES + w];
      sel_type[w]                 = head_type[(int'(rr_q)*WAVES + w)*TYPE_W +: TYPE_W];
      sel_age[w*AGE_W +: AGE_W]   = age_all[(int'(rr_q)*WAVES + w)*AGE_W +: AGE_W];
    end
  end

  // Barrier tracking
  logic bar_room, bar_take;

  wia_bar_track #(.BAR_ENTRIES(BAR_ENTRIES)) u_bar (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_i   (bar_take),
    .release_i(bar_release),
    .room_o   (bar_room),
    .used_o   (bar_used)
  );

  // Per-type eligibility and oldest pick
  logic [WAVES-1:0]      pick_m [NUM_ITYPES];
  logic [NUM_ITYPES-1:0] found_v, keep_v;

  for (genvar t = 0; t < int'(NUM_ITYPES); t++) begin : g_type
    logic [WAVES-1:0] elig;

    if (t == SPEC) begin : g_spec
      always_comb begin
        for (int w = 0; w < int'(WAVES); w++)
          elig[w] = sel_valid[w] && (sel_type[w] == TYPE_W'(t)) && (!sel_bar[w] || bar_room);
      end
    end else begin : g_pipe
      always_comb begin
        for (int w = 0; w < int'(WAVES); w++)
          elig[w] = sel_valid[w] && (sel_type[w] == TYPE_W'(t)) && pipe_ready[t];
      end
    end

    wia_oldest_pick #(.WAVES(WAVES), .AGE_W(AGE_W)) u_pick (
      .elig_i (elig),
      .age_i  (sel_age),
      .pick_o (pick_m[t]),
      .found_o(found_v[t])
    );
  end

  wia_issue_cap #(.NUM_T(NUM_ITYPES), .MAX_ISSUE(MAX_ISSUE)) u_cap (
    .found_i(found_v),
    .keep_o (keep_v)
  );

  // Grant assembly
  logic [WAVES-1:0]        grant_d;
  logic [WAVES*TYPE_W-1:0] type_d;
  logic [SLOTS-1:0]        age_clr;

  always_comb begin
    grant_d  = '0;
    type_d   = '0;
    for (int t = 0; t < int'(NUM_ITYPES); t++) begin
      if (keep_v[t]) begin
        grant_d = grant_d | pick_m[t];
        for (int w = 0; w < int'(WAVES); w++)
          if (pick_m[t][w]) type_d[w*TYPE_W +: TYPE_W] = TYPE_W'(t);
      end
    end
    bar_take = keep_v[SPEC] && |(pick_m[SPEC] & sel_bar);
  end

  always_comb begin
    for (int s = 0; s < int'(NUM_SIMD); s++)
      for (int w = 0; w < int'(WAVES); w++)
        age_clr[s*WAVES + w] = (rr_q == SIMD_W'(s)) && grant_d[w];
  end

  wia_age_track #(.SLOTS(SLOTS), .AGE_W(AGE_W)) u_age (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid_i(head_valid),
    .clear_i(age_clr),
    .age_o  (age_all)
  );

  // Output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_simd  <= SIMD_W'(NUM_SIMD - 1);
      iss_grant <= '0;
      iss_type  <= '0;
    end else begin
      iss_simd  <= rr_q;
      iss_grant <= grant_d;
      iss_type  <= type_d;
    end
  end
endmodule

// File: rtl/wia_issue_chk.sv
module wia_issue_chk #(
  parameter int unsigned NUM_SIMD    = 4,
  parameter int unsigned WAVES       = 10,
  parameter int unsigned MAX_ISSUE   = 5,
  parameter int unsigned BAR_ENTRIES = 16,
  localparam int unsigned SLOTS      = NUM_SIMD * WAVES,
  localparam int unsigned SIMD_W     = $clog2(NUM_SIMD),
  localparam int unsigned BAR_W      = $clog2(BAR_ENTRIES + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [SLOTS-1:0]      head_valid,
  input logic [5:0]            pipe_ready,
  input logic [SIMD_W-1:0]     iss_simd,
  input logic [WAVES-1:0]      iss_grant,
  input logic [WAVES*3-1:0]    iss_type,
  input logic [BAR_W-1:0]      bar_used
);
  logic [SLOTS-1:0] prev_valid;
  logic [7:0]       prev_ready;
  logic [WAVES-1:0] prev_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_valid <= '0;
      prev_ready <= '0;
    end else begin
      prev_valid <= head_valid;
      prev_ready <= {2'b00, pipe_ready};
    end
  end

  always_comb begin
    for (int w = 0; w < int'(WAVES); w++)
      prev_sel[w] = prev_valid[int'(iss_simd)*WAVES + w];
  end

  // R2
  rr_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> iss_simd == (($past(iss_simd) == SIMD_W'(NUM_SIMD - 1)) ? '0 : $past(iss_simd) + 1'b1));

  // R8
  issue_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(iss_grant) <= MAX_ISSUE);

  // R3
  grant_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_grant & ~prev_sel) == '0);

  // R9
  bar_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bar_used <= BAR_W'(BAR_ENTRIES));

  // R9
  bar_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bar_used <= $past(bar_used) + 1'b1) && (bar_used + 1'b1 >= $past(bar_used)));

  for (genvar w = 0; w < int'(WAVES); w++) begin : g_slot
    // R5
    pipe_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_grant[w] && iss_type[w*3 +: 3] != 3'd6) |-> prev_ready[iss_type[w*3 +: 3]]);
    // R10
    type_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !iss_grant[w] |-> iss_type[w*3 +: 3] == 3'd0);
  end
endmodule

bind wave_issue_arbiter wia_issue_chk #(
  .NUM_SIMD   (NUM_SIMD),
  .WAVES      (WAVES),
  .MAX_ISSUE  (MAX_ISSUE),
  .BAR_ENTRIES(BAR_ENTRIES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .head_valid(head_valid),
  .pipe_ready(pipe_ready),
  .iss_simd  (iss_simd),
  .iss_grant (iss_grant),
  .iss_type  (iss_type),
  .bar_used  (bar_used)
);

// File: tb/wave_issue_arbiter_bench.sv
module wave_issue_arbiter_bench;
  localparam int NS = 4;
  localparam int NW = 10;
  localparam int SL = NS * NW;

  logic          clk, rst_n;
  logic [SL-1:0] head_valid, head_barrier;
  logic [SL*3-1:0] head_type;
  logic [5:0]    pipe_ready;
  logic          bar_release;
  logic [1:0]    iss_simd;
  logic [NW-1:0] iss_grant;
  logic [NW*3-1:0] iss_type;
  logic [4:0]    bar_used;

  wave_issue_arbiter u_wave_issue_arbiter (
    .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .head_type(head_type),
    .head_barrier(head_barrier), .pipe_ready(pipe_ready), .bar_release(bar_release),
    .iss_simd(iss_simd), .iss_grant(iss_grant), .iss_type(iss_type), .bar_used(bar_used)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_run, n_fail;
  int m_age [SL];
  int m_rr, m_bar, e_bar;
  logic [NW-1:0]   e_grant;
  logic [NW*3-1:0] e_type;
  logic [1:0]      e_simd;

  // stimulus rows: {valid per slot, type codes (slot 9 first), barrier flags, ready, release}
  localparam int NV = 8;
  localparam logic [56:0] VEC [NV] = '{
    {10'h3FF, 30'o6543210654, 10'h000, 6'h3F, 1'b0},
    {10'h3FF, 30'o2222222222, 10'h000, 6'h3F, 1'b0},
    {10'h0F0, 30'o0011223344, 10'h000, 6'h15, 1'b0},
    {10'h155, 30'o7777666655, 10'h0C0, 6'h3F, 1'b0},
    {10'h2AA, 30'o5544332211, 10'h000, 6'h2A, 1'b1},
    {10'h000, 30'o0000000000, 10'h000, 6'h3F, 1'b0},
    {10'h3FF, 30'o1111100000, 10'h000, 6'h3F, 1'b0},
    {10'h201, 30'o6000000006, 10'h201, 6'h00, 1'b0}
  };

  task automatic set_all(input logic [9:0] v, input logic [29:0] t, input logic [9:0] b);
    for (int s = 0; s < NS; s++) begin
      head_valid[s*NW +: NW]     = v;
      head_type[s*NW*3 +: NW*3]  = t;
      head_barrier[s*NW +: NW]   = b;
    end
  endtask

  task automatic predict();
    int n, best, idx;
    logic elig, take;
    e_grant = '0; e_type = '0; n = 0; take = 1'b0;
    e_simd = m_rr[1:0];
    for (int t = 0; t < 7; t++) begin
      best = -1;
      for (int w = 0; w < NW; w++) begin
        idx  = m_rr*NW + w;
        elig = head_valid[idx] && (head_type[idx*3 +: 3] == t[2:0]) &&
               ((t == 6) ? (!head_barrier[idx] || m_bar < 16) : pipe_ready[t]);
        if (elig && (best < 0 || m_age[idx] > m_age[m_rr*NW + best])) best = w;
      end
      if (best >= 0 && n < 5) begin
        e_grant[best] = 1'b1;
        e_type[best*3 +: 3] = t[2:0];
        n++;
        if (t == 6 && head_barrier[m_rr*NW + best]) take = 1'b1;
      end
    end
    e_bar = m_bar + (take ? 1 : 0) - ((bar_release && m_bar > 0) ? 1 : 0);
  endtask

  task automatic advance();
    for (int i = 0; i < SL; i++) begin
      if (!head_valid[i] || ((i / NW) == m_rr && e_grant[i % NW])) m_age[i] = 0;
      else if (m_age[i] < 15) m_age[i] = m_age[i] + 1;
    end
    m_rr  = (m_rr + 1) % NS;
    m_bar = e_bar;
  endtask

  task automatic step(input string tag);
    predict();
    @(posedge clk);
    advance();
    @(negedge clk);
    n_run++;
    if (iss_grant !== e_grant || iss_type !== e_type || iss_simd !== e_simd || bar_used !== e_bar[4:0]) begin
      n_fail++;
      $display("FAIL %s: simd=%0d grant=%b type=%o bar=%0d, expected simd=%0d grant=%b type=%o bar=%0d",
               tag, iss_simd, iss_grant, iss_type, bar_used, e_simd, e_grant, e_type, e_bar);
    end
  endtask

  task automatic expect_eq(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; head_valid = '0; head_type = '0; head_barrier = '0;
    pipe_ready = '0; bar_release = 1'b0;
    m_rr = 0; m_bar = 0;
    for (int i = 0; i < SL; i++) m_age[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_eq("R1 simd", int'(iss_simd), 3);
    expect_eq("R1 grant", int'(iss_grant), 0);
    expect_eq("R1 type", int'(iss_type), 0);
    expect_eq("R1 bar", int'(bar_used), 0);

    // R2 first selected SIMD is 0
    step("R2 idle");
    expect_eq("R2 first simd", int'(iss_simd), 0);

    // table of patterns: R2 R3 R4 R5 R7 R8 R9 R10
    for (int v = 0; v < NV; v++) begin
      set_all(VEC[v][56:47], VEC[v][46:17], VEC[v][16:7]);
      pipe_ready  = VEC[v][6:1];
      bar_release = VEC[v][0];
      for (int c = 0; c < 6; c++) begin
        step("R3 R4 R5 R7 R8 R10 table");
        if (v == 0 && c == 0) expect_eq("R8 five grants", $countones(iss_grant), 5);
      end
    end
    bar_release = 1'b0;

    // R4 code 7 never granted
    set_all(10'h3FF, 30'o7777777777, 10'h000);
    pipe_ready = 6'h3F;
    step("R4 code7");
    expect_eq("R4 code7 grant", int'(iss_grant), 0);

    // R6 special ignores readiness
    set_all(10'h014, 30'o0000010600, 10'h000);
    pipe_ready = 6'h00;
    step("R6 special");
    expect_eq("R6 special grant", int'(iss_grant), 4);
    expect_eq("R6 special type", int'(iss_type[8:6]), 6);

    // R9 barrier saturation
    set_all(10'h3FF, 30'o6666666666, 10'h3FF);
    for (int c = 0; c < 20; c++) step("R9 fill");
    expect_eq("R9 full count", int'(bar_used), 16);
    step("R9 blocked");
    expect_eq("R9 blocked grant", int'(iss_grant), 0);
    bar_release = 1'b1;
    step("R9 release");
    expect_eq("R9 after release", int'(bar_used), 15);
    bar_release = 1'b0;
    step("R9 refill");
    expect_eq("R9 refill count", int'(bar_used), 16);
    expect_eq("R9 refill grant", $countones(iss_grant), 1);

    // R7 age order: slot 5 waits longer than slot 1
    set_all(10'h000, 30'o0, 10'h000);
    pipe_ready = 6'h00;
    step("R7 clear");
    set_all(10'h020, 30'o0000200000, 10'h000);
    for (int c = 0; c < 6; c++) step("R7 wait5");
    set_all(10'h022, 30'o0000200020, 10'h000);
    for (int c = 0; c < 2; c++) step("R7 wait1");
    pipe_ready = 6'h04;
    step("R7 older wins");
    expect_eq("R7 older wins", int'(iss_grant), 10'h020);
    // R7 saturated ages tie: lowest index wins
    pipe_ready = 6'h00;
    for (int c = 0; c < 25; c++) step("R7 saturate");
    pipe_ready = 6'h04;
    step("R7 tie");
    expect_eq("R7 tie lowest", int'(iss_grant), 10'h002);

    // R5 not ready blocks
    set_all(10'h3FF, 30'o0123450123, 10'h000);
    pipe_ready = 6'h00;
    step("R5 blocked");
    expect_eq("R5 blocked grant", int'(iss_grant), 0);

    // R1 reset in mid-run
    rst_n = 1'b0;
    #1;
    expect_eq("R1 mid reset grant", int'(iss_grant), 0);
    expect_eq("R1 mid reset bar", int'(bar_used), 0);
    expect_eq("R1 mid reset simd", int'(iss_simd), 3);

    finish_run();
  end
endmodule